// File: doc/BRIEF.md
# Coprocessor Integer Execute Unit

This block runs register-to-register integer operations on a private file of sixteen 64-bit registers. A 32-bit operation uses only the low half of each register it touches. A 64-bit operation uses the whole register. Each instruction word names a destination, a first source and a second source, plus a two-bit major code and a three-bit minor code. Together the codes select one of these operations: immediate shift, multiply, multiply-accumulate, multiply-subtract, absolute value, negate, add or subtract. The result is then written to the destination.

A host pulses `issue` with an instruction word. It loads or inspects registers through a write port and a combinational read port. Most operations finish in the clock after issue. Multiplies run on an iterative shift-add engine, one multiplier bit per clock.

A two-state controller sequences the work:
- ST_IDLE accepts instructions. Single-cycle operations write back straight from ST_IDLE, and the controller stays there.
- A multiply-class instruction moves the controller from ST_IDLE to ST_MULT (the transition "start").
- ST_MULT returns to ST_IDLE on the last multiplier step (the transition "finish"), which writes the destination and pulses `done`.
- While in ST_MULT the controller holds ST_MULT on every other step.

Top module: `cx_int_exec`

## Requirements
- R1: After reset all sixteen registers read zero, and `busy` and `done` are low.
- R2: A host write with `host_we` high stores all 64 bits of `host_wdata` into register `host_idx` at the clock edge. `host_rdata` shows register `host_ridx` combinationally.
- R3: Instruction fields are placed as follows: destination in bits 15:12, first source in 19:16, second source in 3:0, major code in 21:20, minor code in 7:5. With major 0 (32-bit) or major 2 (64-bit) the first source is shifted by a signed 7-bit amount. That amount is built from bits 7:5 as its upper three bits and bits 3:0 as its lower four, and its bit 6 is the sign. A non-negative amount shifts left, and amounts at or above the width give zero. A negative amount shifts right arithmetically by its magnitude, and magnitudes at or above the width give all sign bits.
- R4: With major 3 the minor code selects the operation: 0 abs32, 1 abs64, 2 neg32, 3 neg64, 4 add32, 5 add64, 6 sub32, 7 sub64. All arithmetic wraps without saturation.
- R5: The absolute value of the most negative 32-bit or 64-bit number is that same number.
- R6: Every 32-bit operation writes only bits 31:0 of the destination, and bits 63:32 keep their value.
- R7: With major 1, minor 0 gives the low 32 bits of the product of the two low halves. Minor 1 gives the low 64 bits of the 64-bit product.
- R8: With major 1, minor 2 adds the low-half product to the destination's low half. Minor 3 subtracts the low-half product from the destination's low half.
- R9: With major 1 and minor 4 to 7, no register changes, and `done` still pulses one clock after issue.
- R10: `done` pulses one clock after issue for single-cycle operations. It pulses 33 clocks after issue for 32-bit multiply-class operations and 65 clocks after issue for the 64-bit multiply. `busy` is high only between issue and completion of a multiply, and never together with `done`.
- R11: An `issue` raised while `busy` is high is ignored. It changes no register and causes no extra `done` pulse.
- R12: If a host write and a unit writeback target the same register at the same edge, the writeback is kept and the host write is dropped. A host write to a different register at that edge still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | Start strobe for the instruction on `instr` |
| instr | input | 32 | Instruction word |
| host_we | input | 1 | Host register write enable |
| host_idx | input | 4 | Host write register index |
| host_wdata | input | 64 | Host write data |
| host_ridx | input | 4 | Host read register index |
| host_rdata | output | 64 | Host read data, combinational |
| busy | output | 1 | Multiply in progress |
| done | output | 1 | One-clock completion pulse |

## Verification
Two actions can land on one register in the same cycle: the final step of a multiply writing its destination, and a host write. The bench provokes this by counting clocks from issue and placing a host write exactly on the completion edge. It does so once aimed at the multiply's destination and once at a different register. The result is judged by reading both registers back: the product must survive in the first case, and both values must land in the second. A second overlap sends a fresh `issue` in the middle of a multiply. That issue must leave its target unchanged and must not add a `done` pulse.

// File: rtl/cx_pkg.sv
package cx_pkg;
    localparam int FIELD_W = 4;
    localparam int NREG    = 1 << FIELD_W;
    localparam int SHAMT_W = 7;

    typedef enum logic [3:0] {
        OP_NOP, OP_SH32, OP_SH64, OP_MUL32, OP_MUL64, OP_MAC32, OP_MSC32,
        OP_ABS32, OP_ABS64, OP_NEG32, OP_NEG64, OP_ADD32, OP_ADD64,
        OP_SUB32, OP_SUB64
    } cx_op_e;

    typedef enum logic [0:0] {
        ST_IDLE,
        ST_MULT
    } cx_state_e;

    typedef struct packed {
        cx_op_e               op;
        logic [FIELD_W-1:0]   dst;
        logic [FIELD_W-1:0]   src1;
        logic [FIELD_W-1:0]   src2;
        logic [SHAMT_W-1:0]   shamt;
        logic                 is_mul;
        logic                 half;
    } cx_dec_t;
endpackage

// File: rtl/cx_decode.sv
module cx_decode
    import cx_pkg::*;
(
    input  logic [31:0] instr,
    output cx_dec_t     dec
);
    logic [1:0] major;
    logic [2:0] minor;
    logic       unused_bits;

    assign major       = instr[21:20];
    assign minor       = instr[7:5];
    assign unused_bits = ^{instr[31:22], instr[11:8], instr[4]};

    always_comb begin
        dec.dst   = instr[15:12];
        dec.src1  = instr[19:16];
        dec.src2  = instr[3:0];
        dec.shamt = {instr[7:5], instr[3:0]};
        dec.op    = OP_NOP;
        unique case (major)
            2'd0: dec.op = OP_SH32;
            2'd2: dec.op = OP_SH64;
            2'd1: begin
                case (minor)
                    3'd0:    dec.op = OP_MUL32;
                    3'd1:    dec.op = OP_MUL64;
                    3'd2:    dec.op = OP_MAC32;
                    3'd3:    dec.op = OP_MSC32;
                    default: dec.op = OP_NOP;
                endcase
            end
            2'd3: begin
                unique case (minor)
                    3'd0: dec.op = OP_ABS32;
                    3'd1: dec.op = OP_ABS64;
                    3'd2: dec.op = OP_NEG32;
                    3'd3: dec.op = OP_NEG64;
                    3'd4: dec.op = OP_ADD32;
                    3'd5: dec.op = OP_ADD64;
                    3'd6: dec.op = OP_SUB32;
                    3'd7: dec.op = OP_SUB64;
                endcase
            end
        endcase
        dec.is_mul = (dec.op == OP_MUL32) || (dec.op == OP_MUL64) ||
                     (dec.op == OP_MAC32) || (dec.op == OP_MSC32);
        dec.half   = !((dec.op == OP_SH64)  || (dec.op == OP_MUL64) ||
                       (dec.op == OP_ABS64) || (dec.op == OP_NEG64) ||
                       (dec.op == OP_ADD64) || (dec.op == OP_SUB64));
    end
endmodule

// File: rtl/cx_alu.sv
module cx_alu
    import cx_pkg::*;
#(
    parameter int DW = 64
) (
    input  cx_op_e             op,
    input  logic [DW-1:0]      a,
    input  logic [DW-1:0]      b,
    input  logic [SHAMT_W-1:0] shamt,
    output logic [DW-1:0]      res
);
    localparam int HW = DW / 2;

    logic [HW-1:0]      alo, blo, r32, sra32, sll32;
    logic [DW-1:0]      r64, sra64, sll64;
    logic [SHAMT_W-1:0] mag;
    logic               go_right;

    assign alo      = a[HW-1:0];
    assign blo      = b[HW-1:0];
    assign go_right = shamt[SHAMT_W-1];
    assign mag      = go_right ? (~shamt + 1'b1) : shamt;

    always_comb begin
        sra32 = $signed(alo) >>> mag;
        sll32 = alo << mag;
        sra64 = $signed(a) >>> mag;
        sll64 = a << mag;
    end

    always_comb begin
        r32 = '0;
        r64 = '0;
        case (op)
            OP_SH32:  r32 = go_right ? sra32 : sll32;
            OP_SH64:  r64 = go_right ? sra64 : sll64;
            OP_ABS32: r32 = alo[HW-1] ? (~alo + 1'b1) : alo;
            OP_ABS64: r64 = a[DW-1] ? (~a + 1'b1) : a;
            OP_NEG32: r32 = ~alo + 1'b1;
            OP_NEG64: r64 = ~a + 1'b1;
            OP_ADD32: r32 = alo + blo;
            OP_ADD64: r64 = a + b;
            OP_SUB32: r32 = alo - blo;
            OP_SUB64: r64 = a - b;
            default: begin
                r32 = '0;
                r64 = '0;
            end
        endcase
        res = r64 | {{HW{1'b0}}, r32};
    end
endmodule

// File: rtl/cx_mul.sv
module cx_mul #(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          wide,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] prod_nxt,
    output logic          last
);
    localparam int HW = DW / 2;
    localparam int CW = $clog2(DW);

    logic [DW-1:0] mcand, mplier, prod;
    logic [CW-1:0] cnt;
    logic          wide_q;

    assign prod_nxt = prod + (mplier[0] ? mcand : '0);
    assign last     = step && (cnt == (wide_q ? CW'(DW - 1) : CW'(HW - 1)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mcand  <= '0;
            mplier <= '0;
            prod   <= '0;
            cnt    <= '0;
            wide_q <= 1'b0;
        end else if (load) begin
            mcand  <= wide ? a : {{HW{1'b0}}, a[HW-1:0]};
            mplier <= wide ? b : {{HW{1'b0}}, b[HW-1:0]};
            prod   <= '0;
            cnt    <= '0;
            wide_q <= wide;
        end else if (step) begin
            prod   <= prod_nxt;
            mcand  <= mcand << 1;
            mplier <= mplier >> 1;
            cnt    <= cnt + 1'b1;
        end
    end

    // R10
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wide_q) |-> (cnt <= CW'(HW - 1)));
endmodule

// File: rtl/cx_regfile.sv
module cx_regfile
    import cx_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FIELD_W-1:0] ra_idx,
    input  logic [FIELD_W-1:0] rb_idx,
    input  logic [FIELD_W-1:0] rc_idx,
    input  logic [FIELD_W-1:0] rh_idx,
    output logic [DW-1:0]      ra,
    output logic [DW-1:0]      rb,
    output logic [DW-1:0]      rc,
    output logic [DW-1:0]      rh,
    input  logic               ex_we,
    input  logic               ex_lo,
    input  logic [FIELD_W-1:0] ex_idx,
    input  logic [DW-1:0]      ex_data,
    input  logic               h_we,
    input  logic [FIELD_W-1:0] h_idx,
    input  logic [DW-1:0]      h_data
);
    localparam int HW = DW / 2;

    logic [DW-1:0] mem [NREG];
    logic          h_clash;

    assign ra      = mem[ra_idx];
    assign rb      = mem[rb_idx];
    assign rc      = mem[rc_idx];
    assign rh      = mem[rh_idx];
    assign h_clash = ex_we && (h_idx == ex_idx);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
        end else begin
            if (h_we && !h_clash) mem[h_idx] <= h_data;
            if (ex_we) begin
                if (ex_lo) mem[ex_idx][HW-1:0] <= ex_data[HW-1:0];
                else       mem[ex_idx]         <= ex_data;
            end
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_chk
        // R6
        hi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ex_we && ex_lo && ex_idx == FIELD_W'(g))
            |=> (mem[g][DW-1:HW] == $past(mem[g][DW-1:HW])));
        // R12
        exec_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ex_we && !ex_lo && h_we && h_idx == ex_idx && ex_idx == FIELD_W'(g))
            |=> (mem[g] == $past(ex_data)));
    end
endmodule

// File: rtl/cx_int_exec.sv
module cx_int_exec
    import cx_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue,
    input  logic [31:0]        instr,
    input  logic               host_we,
    input  logic [FIELD_W-1:0] host_idx,
    input  logic [DW-1:0]      host_wdata,
    input  logic [FIELD_W-1:0] host_ridx,
    output logic [DW-1:0]      host_rdata,
    output logic               busy,
    output logic               done
);
    localparam int HW = DW / 2;

    cx_state_e          state, state_nxt;
    cx_dec_t            dec;
    cx_op_e             op_q;
    logic [FIELD_W-1:0] dst_q;
    logic [HW-1:0]      base_q;
    logic [DW-1:0]      rd_a, rd_b, rd_c, alu_res, prod;
    logic               mul_load, mul_step, mul_last;
    logic               ex_we, ex_lo, done_nxt;
    logic [FIELD_W-1:0] ex_idx;
    logic [DW-1:0]      ex_data;
    logic               unused_bits;

    assign unused_bits = ^rd_c[DW-1:HW];

    cx_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    cx_regfile #(.DW(DW)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_idx  (dec.src1),
        .rb_idx  (dec.src2),
        .rc_idx  (dec.dst),
        .rh_idx  (host_ridx),
        .ra      (rd_a),
        .rb      (rd_b),
        .rc      (rd_c),
        .rh      (host_rdata),
        .ex_we   (ex_we),
        .ex_lo   (ex_lo),
        .ex_idx  (ex_idx),
        .ex_data (ex_data),
        .h_we    (host_we),
        .h_idx   (host_idx),
        .h_data  (host_wdata)
    );

    cx_alu #(.DW(DW)) u_alu (
        .op    (dec.op),
        .a     (rd_a),
        .b     (rd_b),
        .shamt (dec.shamt),
        .res   (alu_res)
    );

    assign mul_load = (state == ST_IDLE) && issue && dec.is_mul;
    assign mul_step = (state == ST_MULT);

    cx_mul #(.DW(DW)) u_mul (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (mul_load),
        .step     (mul_step),
        .wide     (dec.op == OP_MUL64),
        .a        (rd_a),
        .b        (rd_b),
        .prod_nxt (prod),
        .last     (mul_last)
    );

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (issue && dec.is_mul) state_nxt = ST_MULT;
            ST_MULT: if (mul_last)            state_nxt = ST_IDLE;
        endcase
    end

    // state register and captured operands
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            done   <= 1'b0;
            op_q   <= OP_NOP;
            dst_q  <= '0;
            base_q <= '0;
        end else begin
            state <= state_nxt;
            done  <= done_nxt;
            if (mul_load) begin
                op_q   <= dec.op;
                dst_q  <= dec.dst;
                base_q <= rd_c[HW-1:0];
            end
        end
    end

    // outputs: writeback and completion
    always_comb begin
        ex_we    = 1'b0;
        ex_lo    = 1'b0;
        ex_idx   = dec.dst;
        ex_data  = alu_res;
        done_nxt = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (issue && !dec.is_mul) begin
                    done_nxt = 1'b1;
                    if (dec.op != OP_NOP) begin
                        ex_we = 1'b1;
                        ex_lo = dec.half;
                    end
                end
            end
            ST_MULT: begin
                ex_idx = dst_q;
                if (mul_last) begin
                    done_nxt = 1'b1;
                    ex_we    = 1'b1;
                    ex_lo    = (op_q != OP_MUL64);
                    case (op_q)
                        OP_MAC32: ex_data = {{HW{1'b0}}, base_q + prod[HW-1:0]};
                        OP_MSC32: ex_data = {{HW{1'b0}}, base_q - prod[HW-1:0]};
                        default:  ex_data = prod;
                    endcase
                end
            end
        endcase
    end

    assign busy = (state == ST_MULT);

    // R10
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R10
    busy_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));
    // R11
    ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && issue && !mul_last) |=> busy);
    // R5
    abs_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE) && issue && dec.op == OP_ABS32)
        |-> (!alu_res[HW-1] || rd_a[HW-1:0] == {1'b1, {(HW-1){1'b0}}}));
endmodule

// File: tb/sim_cx_int_exec.sv
module sim_cx_int_exec;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [31:0] instr = '0;
    logic        host_we = 1'b0;
    logic [3:0]  host_idx = '0;
    logic [63:0] host_wdata = '0;
    logic [3:0]  host_ridx = '0;
    logic [63:0] host_rdata;
    logic        busy, done;

    int checks = 0;
    int fails  = 0;
    logic [63:0] mdl [16];

    cx_int_exec u0 (
        .clk(clk), .rst_n(rst_n), .issue(issue), .instr(instr),
        .host_we(host_we), .host_idx(host_idx), .host_wdata(host_wdata),
        .host_ridx(host_ridx), .host_rdata(host_rdata),
        .busy(busy), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [1:0] mj, input logic [2:0] mn,
                                       input logic [3:0] d, input logic [3:0] s1,
                                       input logic [3:0] s2);
        return {10'd0, mj, s1, d, 4'd0, mn, 1'b0, s2};
    endfunction

    function automatic logic [31:0] mksh(input logic [1:0] mj, input logic [3:0] d,
                                         input logic [3:0] s1, input int amt);
        logic [6:0] f;
        f = 7'(amt);
        return mk(mj, f[6:4], d, s1, f[3:0]);
    endfunction

    // expected {write, new destination value}
    function automatic logic [64:0] model(input logic [31:0] ins);
        logic [1:0]  mj;
        logic [2:0]  mn;
        logic [63:0] A, B, D, r;
        logic [31:0] al, bl, dl, q;
        logic        w, half;
        int          sh, n;
        mj = ins[21:20];
        mn = ins[7:5];
        A = mdl[ins[19:16]];
        B = mdl[ins[3:0]];
        D = mdl[ins[15:12]];
        al = A[31:0]; bl = B[31:0]; dl = D[31:0];
        sh = int'({ins[7:5], ins[3:0]});
        if (sh >= 64) sh = sh - 128;
        n = (sh < 0) ? -sh : sh;
        w = 1'b1; half = 1'b1; q = '0; r = D;
        case (mj)
            2'd0: begin
                if (sh >= 0) q = (sh >= 32) ? 32'd0 : (al << sh);
                else         q = (n >= 32) ? {32{al[31]}} : 32'($signed(al) >>> n);
            end
            2'd2: begin
                half = 1'b0;
                if (sh >= 0) r = (sh >= 64) ? 64'd0 : (A << sh);
                else         r = (n >= 64) ? {64{A[63]}} : 64'($signed(A) >>> n);
            end
            2'd1: begin
                case (mn)
                    3'd0: q = al * bl;
                    3'd1: begin half = 1'b0; r = A * B; end
                    3'd2: q = dl + al * bl;
                    3'd3: q = dl - al * bl;
                    default: w = 1'b0;
                endcase
            end
            default: begin
                case (mn)
                    3'd0: q = al[31] ? -al : al;
                    3'd1: begin half = 1'b0; r = A[63] ? -A : A; end
                    3'd2: q = -al;
                    3'd3: begin half = 1'b0; r = -A; end
                    3'd4: q = al + bl;
                    3'd5: begin half = 1'b0; r = A + B; end
                    3'd6: q = al - bl;
                    default: begin half = 1'b0; r = A - B; end
                endcase
            end
        endcase
        if (!w) r = D;
        else if (half) r = {D[63:32], q};
        return {w, r};
    endfunction

    function automatic int exp_lat(input logic [31:0] ins);
        if (ins[21:20] == 2'd1 && ins[7:5] <= 3'd3) return (ins[7:5] == 3'd1) ? 65 : 33;
        return 1;
    endfunction

    task automatic host_write(input logic [3:0] idx, input logic [63:0] val);
        @(negedge clk);
        host_we = 1'b1; host_idx = idx; host_wdata = val;
        @(posedge clk);
        #1 host_we = 1'b0;
        mdl[idx] = val;
    endtask

    task automatic read_reg(input logic [3:0] idx, output logic [63:0] val);
        host_ridx = idx;
        #1 val = host_rdata;
    endtask

    task automatic run_op(input logic [31:0] ins, input string tag);
        logic [64:0] e;
        logic [63:0] got;
        int lat;
        e = model(ins);
        @(negedge clk);
        instr = ins; issue = 1'b1;
        @(posedge clk);
        #1 issue = 1'b0;
        lat = 1;
        while (!done && lat < 300) begin
            @(posedge clk);
            #1 lat++;
        end
        chk({tag, " latency R10"}, 64'(lat), 64'(exp_lat(ins)));
        if (e[64]) mdl[ins[15:12]] = e[63:0];
        read_reg(ins[15:12], got);
        chk({tag, " result"}, got, mdl[ins[15:12]]);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        logic [63:0] v;
        logic [64:0] e;
        void'($urandom(32'd20240517));
        for (int i = 0; i < 16; i++) mdl[i] = '0;
        #(CLK_PERIOD * 3);
        #1;
        // R1 reset state
        chk("R1 busy", 64'(busy), 64'd0);
        chk("R1 done", 64'(done), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 16; i++) begin
            read_reg(4'(i), v);
            chk("R1 reg zero", v, 64'd0);
        end

        // R2 host path
        host_write(4'd1, 64'hDEAD_BEEF_1234_5678);
        read_reg(4'd1, v);
        chk("R2 host write", v, 64'hDEAD_BEEF_1234_5678);
        host_write(4'd2, 64'hFFFF_FFFF_8000_0000);
        host_write(4'd3, 64'h8000_0000_0000_0000);
        host_write(4'd4, 64'h0000_0001_0000_0003);
        host_write(4'd5, 64'h1111_2222_FFFF_FFFE);

        // R3 shifts, R6 upper half kept
        run_op(mksh(2'd0, 4'd6, 4'd1, 4),   "R3 sh32 left 4");
        run_op(mksh(2'd0, 4'd7, 4'd2, -4),  "R3 sh32 right 4");
        run_op(mksh(2'd0, 4'd7, 4'd2, -64), "R3 sh32 right 64");
        run_op(mksh(2'd0, 4'd8, 4'd1, 40),  "R3 sh32 left 40");
        host_write(4'd9, 64'hAAAA_5555_0000_0001);
        run_op(mksh(2'd0, 4'd9, 4'd1, 1),   "R6 sh32 keeps upper");
        run_op(mksh(2'd2, 4'd10, 4'd3, -1), "R3 sh64 right 1");
        run_op(mksh(2'd2, 4'd10, 4'd3, -64),"R3 sh64 right 64");
        run_op(mksh(2'd2, 4'd11, 4'd1, 63), "R3 sh64 left 63");

        // R4 / R5 arithmetic
        run_op(mk(2'd3, 3'd4, 4'd12, 4'd5, 4'd4), "R4 add32 wrap");
        run_op(mk(2'd3, 3'd7, 4'd12, 4'd4, 4'd5), "R4 sub64");
        run_op(mk(2'd3, 3'd2, 4'd12, 4'd5, 4'd0), "R4 neg32");
        run_op(mk(2'd3, 3'd3, 4'd13, 4'd1, 4'd0), "R4 neg64");
        run_op(mk(2'd3, 3'd0, 4'd13, 4'd2, 4'd0), "R5 abs32 min");
        run_op(mk(2'd3, 3'd1, 4'd14, 4'd3, 4'd0), "R5 abs64 min");
        run_op(mk(2'd3, 3'd0, 4'd14, 4'd5, 4'd0), "R4 abs32 neg");

        // R7 / R8 multiplies
        run_op(mk(2'd1, 3'd0, 4'd6, 4'd5, 4'd4), "R7 mul32");
        run_op(mk(2'd1, 3'd1, 4'd7, 4'd1, 4'd4), "R7 mul64");
        run_op(mk(2'd1, 3'd2, 4'd9, 4'd4, 4'd5), "R8 mac32");
        run_op(mk(2'd1, 3'd3, 4'd9, 4'd1, 4'd4), "R8 msc32");

        // R9 out-of-scope minor codes
        run_op(mk(2'd1, 3'd5, 4'd1, 4'd2, 4'd3), "R9 no write");
        run_op(mk(2'd1, 3'd7, 4'd4, 4'd2, 4'd3), "R9 no write");

        // R11 issue while busy
        begin
            logic [63:0] keep;
            e = model(mk(2'd1, 3'd0, 4'd3, 4'd1, 4'd5));
            keep = mdl[10];
            @(negedge clk);
            instr = mk(2'd1, 3'd0, 4'd3, 4'd1, 4'd5); issue = 1'b1;
            @(posedge clk);
            #1 issue = 1'b0;
            repeat (5) @(posedge clk);
            #1 instr = mk(2'd3, 3'd5, 4'd10, 4'd1, 4'd1); issue = 1'b1;
            @(posedge clk);
            #1 issue = 1'b0;
            chk("R11 still busy", 64'(busy), 64'd1);
            while (!done) @(posedge clk);
            #1;
            mdl[3] = e[63:0];
            read_reg(4'd10, v);
            chk("R11 ignored target", v, keep);
            read_reg(4'd3, v);
            chk("R11 product", v, mdl[3]);
            @(posedge clk);
            #1 chk("R11 single done", 64'(done), 64'd0);
        end

        // R12 writeback vs host write on same edge
        for (int t = 0; t < 2; t++) begin
            logic [3:0] hidx;
            hidx = (t == 0) ? 4'd4 : 4'd5;
            e = model(mk(2'd1, 3'd1, 4'd4, 4'd1, 4'd9));
            @(negedge clk);
            instr = mk(2'd1, 3'd1, 4'd4, 4'd1, 4'd9); issue = 1'b1;
            @(posedge clk);
            #1 issue = 1'b0;
            repeat (63) @(posedge clk);
            #1 host_we = 1'b1; host_idx = hidx; host_wdata = 64'h0123_4567_89AB_CDEF;
            @(posedge clk);
            #1 host_we = 1'b0;
            chk("R12 done on collision edge", 64'(done), 64'd1);
            if (t == 1) mdl[5] = 64'h0123_4567_89AB_CDEF;
            mdl[4] = e[63:0];
            read_reg(4'd4, v);
            chk("R12 writeback kept", v, mdl[4]);
            read_reg(4'd5, v);
            chk("R12 other register", v, mdl[5]);
        end

        // constrained random mix
        for (int k = 0; k < 200; k++) begin
            int cls;
            logic [31:0] ins;
            string tag;
            cls = $urandom % 5;
            ins = $urandom;
            if (k % 40 == 0) host_write(4'($urandom), {$urandom, $urandom});
            case (cls)
                0: begin ins[21:20] = 2'd0; tag = "R3 rand sh32"; end
                1: begin ins[21:20] = 2'd2; tag = "R3 rand sh64"; end
                2: begin ins[21:20] = 2'd1; ins[7:5] = 3'($urandom % 4);
                         tag = (ins[7:5] >= 3'd2) ? "R8 rand mac" : "R7 rand mul"; end
                default: begin ins[21:20] = 2'd3; tag = "R4 rand alu"; end
            endcase
            run_op(ins, tag);
        end

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule